// File: doc/BRIEF.md
# Asynchronous Static Memory Sequencer

This block sits between a clocked host and an external asynchronous static memory of 131,072 bytes. The host hands it one request at a time (read or write, a 17-bit word address and, for writes, one data byte). The block then plays out a strobe sequence on the memory pins. Every phase of that sequence lasts a whole number of clock cycles, worked out at elaboration time from the clock period and the memory's speed grade. Each phase is rounded up so that the memory's minimum limits hold: cycle time, access time, write pulse width, data overlap and address-to-end-of-write. When the sequence ends, the block gives the host a one-cycle completion pulse, with the captured byte for a read.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a host that keeps `req_valid` high is simply held off until the running access has completed. Request fields seen while `req_ready` is low are ignored. The response side has no back-pressure: `rsp_done` is a single-cycle pulse, and `rsp_rdata` holds its value until the next read completes.

The memory has two chip enables, one active low and one active high. Between accesses the block drops both to their inactive levels, so the memory sits in standby with its data pins released. The data bus is split into an outgoing byte, an incoming byte and a drive enable, for a pad cell outside this block.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset, `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1, `rsp_done`=0 and `rsp_rdata`=0.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the cycle after `rsp_done`, and request fields that change while it is low have no effect.
- R3: A read holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for N_RD cycles. It samples `mem_dq_in` on the edge that ends them and shows it on `rsp_rdata` together with `rsp_done`.
- R4: A write asserts both enables and drives `mem_dq_out` (with `mem_dq_oe`=1) for N_SU setup cycles with `mem_we_n`=1, then N_WP cycles with `mem_we_n`=0, then N_REC cycles with `mem_we_n`=1. `mem_oe_n` stays 1 throughout.
- R5: The phase counts are ceil(ns/CLK_NS): N_RD from the largest of read cycle, address access and output-enable access; N_WP from the larger of pulse width and data overlap; N_SU = max(1, ceil(tAW)-N_WP); N_REC = max(1, ceil(tWC)-N_SU-N_WP). At 4 ns and the middle grade (55/55/30 read, 55/40/50/25 write), these counts are 14, 10, 3 and 1.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. The block releases the bus in the completion cycle that follows every write.
- R7: `mem_addr` holds the accepted address, unchanged, for every cycle in which the chip enables are asserted.
- R8: `rsp_done` is high for exactly one cycle per access, in the cycle after the last strobe phase, with both enables inactive. `rsp_rdata` changes only when a read completes.
- R9: While idle, `mem_ce1_n`=1, `mem_ce2`=0, `mem_dq_oe`=0, `mem_we_n`=1 and `mem_oe_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte from the most recent read |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_in | input | 8 | Byte returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
A phase counter or state register that slips shows at the pins in the cycle the slip happens. The bench compares every strobe, the address and the write byte against its own timeline on every clock, so a strobe that moves one cycle early or late is reported in that cycle. A phase that comes out too short shows up in a different way. The memory model in the bench returns a corrupted byte when the read access time has not elapsed, and it reports a write pulse, data overlap or address window below its limit at the rising edge of the write strobe. A wrong capture or a lost completion appears one cycle later, on `rsp_rdata` or `rsp_done`.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_READ    = 3'd1,
    PH_WSETUP  = 3'd2,
    PH_WPULSE  = 3'd3,
    PH_WRECOV  = 3'd4,
    PH_FINISH  = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    LIM_RC, LIM_AA, LIM_OE, LIM_WC, LIM_WP, LIM_AW, LIM_DW
  } limit_e;

  // Minimum timing limit in ns for a speed grade (0 fast, 1 middle, 2 slow)
  function automatic int limit_ns(input int grade, input limit_e which);
    int r;
    r = 70;
    case (grade)
      0: case (which)
           LIM_RC: r = 35;  LIM_AA: r = 35;  LIM_OE: r = 25;
           LIM_WC: r = 35;  LIM_WP: r = 25;  LIM_AW: r = 30;
           LIM_DW: r = 20;  default: r = 35;
         endcase
      1: case (which)
           LIM_RC: r = 55;  LIM_AA: r = 55;  LIM_OE: r = 30;
           LIM_WC: r = 55;  LIM_WP: r = 40;  LIM_AW: r = 50;
           LIM_DW: r = 25;  default: r = 55;
         endcase
      default: case (which)
           LIM_RC: r = 70;  LIM_AA: r = 70;  LIM_OE: r = 35;
           LIM_WC: r = 70;  LIM_WP: r = 45;  LIM_AW: r = 60;
           LIM_DW: r = 30;  default: r = 70;
         endcase
    endcase
    return r;
  endfunction

  function automatic int cycles_for(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int RD_CYC  = 14,
  parameter int WSU_CYC = 3,
  parameter int WP_CYC  = 10,
  parameter int WRC_CYC = 1,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_on,
  output logic             oe_on,
  output logic             we_on,
  output logic             drive_on,
  output logic             done
);

  phase_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      PH_IDLE:   if (req_valid) nxt = req_write ? PH_WSETUP : PH_READ;
      PH_READ:   if (tmr_zero)  nxt = PH_FINISH;
      PH_WSETUP: if (tmr_zero)  nxt = PH_WPULSE;
      PH_WPULSE: if (tmr_zero)  nxt = PH_WRECOV;
      PH_WRECOV: if (tmr_zero)  nxt = PH_FINISH;
      default:                  nxt = PH_IDLE;
    endcase
  end

  assign req_ready = (state == PH_IDLE);
  assign accept    = req_ready & req_valid;
  assign capture   = (state == PH_READ) & tmr_zero;
  assign tmr_load  = (nxt != state);

  always_comb begin
    case (nxt)
      PH_READ:   tmr_val = CNT_W'(RD_CYC - 1);
      PH_WSETUP: tmr_val = CNT_W'(WSU_CYC - 1);
      PH_WPULSE: tmr_val = CNT_W'(WP_CYC - 1);
      PH_WRECOV: tmr_val = CNT_W'(WRC_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  // Strobes registered from the next phase so the pins change glitch-free
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      ce_on    <= 1'b0;
      oe_on    <= 1'b0;
      we_on    <= 1'b0;
      drive_on <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= nxt;
      ce_on    <= (nxt != PH_IDLE) && (nxt != PH_FINISH);
      oe_on    <= (nxt == PH_READ);
      we_on    <= (nxt == PH_WPULSE);
      drive_on <= (nxt == PH_WSETUP) || (nxt == PH_WPULSE) || (nxt == PH_WRECOV);
      done     <= (nxt == PH_FINISH);
    end
  end

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 4,
  parameter int GRADE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int RD_NS   = imax(imax(limit_ns(GRADE, LIM_RC), limit_ns(GRADE, LIM_AA)),
                                limit_ns(GRADE, LIM_OE));
  localparam int RD_CYC  = cycles_for(RD_NS, CLK_NS);
  localparam int WP_CYC  = cycles_for(imax(limit_ns(GRADE, LIM_WP), limit_ns(GRADE, LIM_DW)), CLK_NS);
  localparam int AW_CYC  = cycles_for(limit_ns(GRADE, LIM_AW), CLK_NS);
  localparam int WSU_CYC = imax(1, AW_CYC - WP_CYC);
  localparam int WC_CYC  = cycles_for(limit_ns(GRADE, LIM_WC), CLK_NS);
  localparam int WRC_CYC = imax(1, WC_CYC - WSU_CYC - WP_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(WSU_CYC, WRC_CYC));
  localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

  logic             accept, capture, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             ce_on, oe_on, we_on, drive_on;

  sramc_fsm #(
    .RD_CYC (RD_CYC),
    .WSU_CYC(WSU_CYC),
    .WP_CYC (WP_CYC),
    .WRC_CYC(WRC_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .tmr_zero (tmr_zero),
    .req_ready(req_ready),
    .accept   (accept),
    .capture  (capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ce_on    (ce_on),
    .oe_on    (oe_on),
    .we_on    (we_on),
    .drive_on (drive_on),
    .done     (rsp_done)
  );

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rsp_rdata (rsp_rdata)
  );

  assign mem_ce1_n = ~ce_on;
  assign mem_ce2   = ce_on;
  assign mem_oe_n  = ~oe_on;
  assign mem_we_n  = ~we_on;
  assign mem_dq_oe = drive_on;

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CLK_NS = 4,
  parameter int GRADE  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int MIN_WP = cycles_for(imax(limit_ns(GRADE, LIM_WP), limit_ns(GRADE, LIM_DW)), CLK_NS);

  logic [7:0] we_low;

  always_ff @(posedge clk) begin
    if (!rst_n)        we_low <= '0;
    else if (!mem_we_n) we_low <= (we_low == 8'hFF) ? we_low : we_low + 8'd1;
    else               we_low <= '0;
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R6
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R4
  AST_DATA_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce1_n && mem_ce2)); // R4
  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_low) >= MIN_WP)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8
  AST_DONE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_ce1_n && !mem_ce2)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> !req_ready); // R2
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && !mem_dq_oe && mem_we_n && mem_oe_n)); // R9

endmodule

bind sramc_ctrl sramc_chk #(.ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .GRADE(GRADE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .mem_addr (mem_addr),
  .mem_ce1_n(mem_ce1_n),
  .mem_ce2  (mem_ce2),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sramc_ctrl_tb.sv
module sramc_ctrl_tb;

  localparam int CLK_NS = 4;
  localparam int T_RC = 55, T_AA = 55, T_OE = 30;
  localparam int T_WC = 55, T_WP = 40, T_AW = 50, T_DW = 25;
  localparam int N_RD  = (T_RC + CLK_NS - 1) / CLK_NS;
  localparam int N_WP  = (T_WP + CLK_NS - 1) / CLK_NS;
  localparam int N_SU  = ((T_AW + CLK_NS - 1) / CLK_NS) - N_WP;
  localparam int N_REC = ((T_WC + CLK_NS - 1) / CLK_NS) - N_SU - N_WP;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  sramc_ctrl #(.CLK_NS(CLK_NS), .GRADE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [7:0] ref_mem [int];
  logic [7:0] mdl_mem [int];
  logic [7:0] last_rd = 8'h00;

  // {ce1_n, ce2, we_n, oe_n, dq_oe, ready, done}
  wire [6:0] obs = {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_done};
  localparam logic [6:0] V_IDLE = 7'b1011010;
  localparam logic [6:0] V_FIN  = 7'b1011001;
  localparam logic [6:0] V_READ = 7'b0110000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory with timing checks, evaluated away from the active edge
  int acc = 0, wel = 0, dst = 0, acyc = 0, aw_end = 0;
  logic [16:0] prev_a = '0, wa = '0;
  logic [7:0]  prev_d = '0, wd = '0, rv;
  bit act;
  initial mem_dq_in = 8'h00;

  always @(negedge clk) begin
    if (!rst_n) begin
      acc = 0; wel = 0; dst = 0; acyc = 0; aw_end = 0;
      mem_dq_in = 8'h00;
    end else begin
      act = !mem_ce1_n && mem_ce2;
      if (act && !mem_oe_n && mem_dq_oe) chk(1'b0, "R6", "bus driven with output enable low", 1, 0);
      acyc = (act && mem_addr == prev_a) ? acyc + 1 : (act ? 1 : 0);
      if (act && !mem_we_n) begin
        dst = (wel > 0 && mem_dq_out == prev_d) ? dst + 1 : 1;
        wel++;
        aw_end = acyc; wd = mem_dq_out; wa = mem_addr;
        if (!mem_dq_oe) chk(1'b0, "R4", "data not driven in write pulse", 0, 1);
      end else if (wel > 0) begin
        chk(wel * CLK_NS >= T_WP, "R5", "write pulse ns", wel * CLK_NS, T_WP);
        chk(dst * CLK_NS >= T_DW, "R5", "data overlap ns", dst * CLK_NS, T_DW);
        chk(aw_end * CLK_NS >= T_AW, "R5", "address to end of write ns", aw_end * CLK_NS, T_AW);
        mdl_mem[int'(wa)] = wd;
        wel = 0; dst = 0;
      end
      if (act && !mem_oe_n && mem_we_n) acc++; else acc = 0;
      rv = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00;
      mem_dq_in = (acc * CLK_NS >= T_AA && acc * CLK_NS >= T_OE) ? rv : ~rv;
      prev_a = mem_addr; prev_d = mem_dq_out;
    end
  end

  // Drive one access from an idle negedge and follow it cycle by cycle
  task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    logic [7:0] exp_rd;
    logic [6:0] v;
    int total;
    exp_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    total = wr ? (N_SU + N_WP + N_REC) : N_RD;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (k == 1) begin  // R2: fields change while busy and must be ignored
        req_addr = ~a; req_wdata = ~d; req_write = ~wr;
      end
      if (k == total) req_valid = 1'b0;
      if (wr) v = {1'b0, 1'b1, !(k > N_SU && k <= N_SU + N_WP), 1'b1, 1'b1, 1'b0, 1'b0};
      else    v = V_READ;
      chk(obs == v, wr ? "R4" : "R3", "strobe pattern", 32'(obs), 32'(v));
      chk(mem_addr == a, "R7", "address held", 32'(mem_addr), 32'(a));
      if (wr) chk(mem_dq_out == d, "R4", "write byte", 32'(mem_dq_out), 32'(d));
    end
    @(negedge clk);
    chk(obs == V_FIN, "R8", "completion cycle", 32'(obs), 32'(V_FIN));
    if (!wr) begin
      chk(rsp_rdata == exp_rd, "R3", "read byte", 32'(rsp_rdata), 32'(exp_rd));
      last_rd = exp_rd;
    end else begin
      chk(rsp_rdata == last_rd, "R8", "read byte kept over write", 32'(rsp_rdata), 32'(last_rd));
      ref_mem[int'(a)] = d;
    end
    @(negedge clk);
    chk(obs == V_IDLE, "R9", "standby after access", 32'(obs), 32'(V_IDLE));
    chk(rsp_rdata == last_rd, "R8", "read byte holds", 32'(rsp_rdata), 32'(last_rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [16:0] ra [$];
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs == V_IDLE, "R1", "reset pins", 32'(obs), 32'(V_IDLE));
    chk(rsp_rdata == 8'h00, "R1", "reset read byte", 32'(rsp_rdata), 0);

    // R9: idle for a while with valid low stays in standby
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(obs == V_IDLE, "R9", "idle hold", 32'(obs), 32'(V_IDLE));
    end

    run_op(1'b0, 17'h00000, 8'h00);      // unwritten location
    run_op(1'b1, 17'h00000, 8'h5A);
    run_op(1'b1, 17'h1FFFF, 8'hA5);
    run_op(1'b0, 17'h1FFFF, 8'h00);
    run_op(1'b0, 17'h00000, 8'h00);
    run_op(1'b1, 17'h00000, 8'hFF);       // overwrite, back to back
    run_op(1'b0, 17'h00000, 8'h00);

    for (int i = 0; i < 24; i++) begin
      logic [16:0] a;
      a = 17'($urandom);
      ra.push_back(a);
      run_op(1'b1, a, 8'($urandom));
      run_op(1'b0, a, 8'h00);
    end
    foreach (ra[i]) run_op(1'b0, ra[i], 8'h00);  // read back after later writes

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule